// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable model of a single-port synchronous SRAM with an internal two-bit burst sequencer. Address, write data, chip selects, burst strobes and write controls are all captured on the rising clock edge. The array is built from four byte lanes of 8 bits each. A transfer starts from either of two start strobes. One strobe is meant for a processor and can only start reads. The other is meant for a memory controller and can start reads or writes. After a start, an advance input steps a two-bit offset counter. A mode input chooses whether that counter walks the four-word group in wrapping-increment order or in XOR order.

Read data reaches the output by one of two paths. In flow-through mode it comes straight from the array. In pipelined mode it passes through one extra output register. A deselect travels down the read path to the same depth as a read, so the output bus keeps driving until the second edge after the deselect. Output enable and sleep gate the bus drive without waiting for a clock. While sleep is high the array is neither read nor written. The output is a tri-state model: a data bus plus a separate drive-enable signal.

Top module: `sync_burst_sram`

## Requirements
- R1: The chip counts as selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A processor start strobe sampled while the chip is not selected starts nothing, and an active burst keeps its current address.
- R2: A cycle started by `start_cpu_n` is always a read. Any write controls sampled on that edge leave the array unchanged.
- R3: `start_ctl_n` low with the chip selected loads `addr` and reads or writes it. `start_ctl_n` low with the chip not selected is a deselect.
- R4: The burst offset counter steps only on edges with `advance_n`=0 during an active burst. With `advance_n`=1 the same address is accessed again.
- R5: With `linear_order`=0, access k of a burst uses word offset (start offset XOR k), counted within the aligned group of four words.
- R6: With `linear_order`=1, access k uses word offset (start offset + k) mod 4. The address wraps inside the aligned four-word group.
- R7: `wr_all_n`=0 writes all four byte lanes, whatever `wr_bytes_n` and `lane_n` are.
- R8: With `wr_all_n`=1 and `wr_bytes_n`=0, the only lanes written are those with `lane_n[i]`=0, where lane i is data bits 8i+7 to 8i. With both write controls high, the cycle is a read.
- R9: With `pipe_mode`=0, data read at an edge is driven from just after that same edge.
- R10: With `pipe_mode`=1, data read at an edge is driven from just after the following edge.
- R11: After a deselect, the bus keeps its previous drive state and data through the next edge, and stops driving after the second edge. This holds in both modes.
- R12: While `sleep_req`=1, the bus does not drive, no edge writes the array, and the burst state is held. Stored words survive.
- R13: `out_en_n`=1 removes the bus drive at once, with no clock edge, and leaves the read pipeline untouched.
- R14: While `rst_n`=0 and after its release, the bus does not drive until a read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state (array not cleared) |
| addr | input | ADDR_W | Word address loaded by a start strobe |
| din | input | 8*LANES | Write data |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| start_cpu_n | input | 1 | Processor start strobe (read only), active low |
| start_ctl_n | input | 1 | Controller start strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, all lanes, active low |
| wr_bytes_n | input | 1 | Byte-write qualifier, active low |
| lane_n | input | LANES | Per-lane write strobes, active low |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through |
| linear_order | input | 1 | 1 = wrapping increment order, 0 = XOR order |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| dout | output | 8*LANES | Read data bus |
| dout_drive | output | 1 | Bus drive enable for the tri-state model |

## Verification
The hardest case to reach is a deselect that lands right behind a read while the output mode differs from the one in use a few cycles earlier. The drive then depends on two pipeline stages and on the mode at the moment of sampling. Directed sequences place a deselect one edge after a read in each mode and check drive and data on both following edges. A long random phase switches the output mode in the middle of traffic and mixes strobes, unselected starts, sleep and output-enable pulses. Every cycle is compared with a cycle-level reference model.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_DESEL = 2'd1,
        K_READ  = 2'd2,
        K_WRITE = 2'd3
    } access_e;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sleep_req,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             start_cpu_n,
    input  logic             start_ctl_n,
    input  logic             advance_n,
    input  logic             wr_all_n,
    input  logic             wr_bytes_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             active_q,
    output access_e          kind,
    output logic             load,
    output logic             step,
    output logic [LANES-1:0] lane_we,
    output logic             active_d
);
    logic             selected;
    logic             cpu_go;
    logic [LANES-1:0] wmask;

    always_comb begin
        selected = !sel_a_n && sel_b && !sel_c_n;
        cpu_go   = !start_cpu_n && selected;
        if (!wr_all_n)       wmask = '1;
        else if (!wr_bytes_n) wmask = ~lane_n;
        else                  wmask = '0;

        kind     = K_NONE;
        load     = 1'b0;
        step     = 1'b0;
        lane_we  = '0;
        active_d = active_q;
        if (sleep_req) begin
            kind = K_NONE;
        end else if (cpu_go) begin
            load     = 1'b1;
            kind     = K_READ;
            active_d = 1'b1;
        end else if (!start_ctl_n) begin
            if (selected) begin
                load     = 1'b1;
                active_d = 1'b1;
                kind     = (|wmask) ? K_WRITE : K_READ;
                lane_we  = wmask;
            end else begin
                kind     = K_DESEL;
                active_d = 1'b0;
            end
        end else if (active_q) begin
            step    = !advance_n;
            kind    = (|wmask) ? K_WRITE : K_READ;
            lane_we = wmask;
        end else begin
            kind = K_DESEL;
        end
    end
endmodule

// File: rtl/sbs_burst.sv
module sbs_burst #(
    parameter int AW = 6,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          linear,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] acc_addr
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [CW-1:0] cnt;
    } burst_t;

    burst_t        st_d, st_q;
    logic [CW-1:0] off;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base = start_addr;
            st_d.cnt  = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        off      = linear ? (st_d.base[CW-1:0] + st_d.cnt) : (st_d.base[CW-1:0] ^ st_d.cnt);
        acc_addr = {st_d.base[AW-1:CW], off};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: counter frozen without advance
    a_r4_hold_without_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(st_q.cnt));
    // R4: one step per advance
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && step) |=> (st_q.cnt == CW'($past(st_q.cnt) + 1'b1)));
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [8*LANES-1:0]   din,
    input  logic                 sel_a_n,
    input  logic                 sel_b,
    input  logic                 sel_c_n,
    input  logic                 start_cpu_n,
    input  logic                 start_ctl_n,
    input  logic                 advance_n,
    input  logic                 wr_all_n,
    input  logic                 wr_bytes_n,
    input  logic [LANES-1:0]     lane_n,
    input  logic                 pipe_mode,
    input  logic                 linear_order,
    input  logic                 out_en_n,
    input  logic                 sleep_req,
    output logic [8*LANES-1:0]   dout,
    output logic                 dout_drive
);
    localparam int DW    = 8 * LANES;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] rd_addr;
        logic              rd_v;
        logic              dsel;
        logic [DW-1:0]     dat;
        logic              v2;
    } out_t;

    out_t              st_d, st_q;
    access_e           kind;
    logic              load, step, active_d;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [DW-1:0]     rd_word;
    logic              raw_v;

    sbs_decode #(.LANES(LANES)) u_dec (
        .sleep_req  (sleep_req),
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .sel_c_n    (sel_c_n),
        .start_cpu_n(start_cpu_n),
        .start_ctl_n(start_ctl_n),
        .advance_n  (advance_n),
        .wr_all_n   (wr_all_n),
        .wr_bytes_n (wr_bytes_n),
        .lane_n     (lane_n),
        .active_q   (st_q.active),
        .kind       (kind),
        .load       (load),
        .step       (step),
        .lane_we    (lane_we),
        .active_d   (active_d)
    );

    sbs_burst #(.AW(ADDR_W), .CW(2)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .linear    (linear_order),
        .start_addr(addr),
        .acc_addr  (acc_addr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];
        always_ff @(posedge clk) begin
            if (lane_we[g]) lane_mem[acc_addr] <= din[8*g +: 8];
        end
        assign rd_word[8*g +: 8] = lane_mem[st_q.rd_addr];
    end

    always_comb begin
        st_d         = st_q;
        st_d.active  = active_d;
        st_d.rd_addr = acc_addr;
        st_d.rd_v    = (kind == K_READ);
        st_d.dsel    = (kind == K_DESEL);
        st_d.dat     = rd_word;
        st_d.v2      = st_q.rd_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (pipe_mode || st_q.dsel) begin
            raw_v = st_q.v2;
            dout  = st_q.dat;
        end else begin
            raw_v = st_q.rd_v;
            dout  = rd_word;
        end
        dout_drive = raw_v && !out_en_n && !sleep_req;
    end

    // R2: processor start never writes
    a_r2_cpu_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_cpu_n && !sel_a_n && sel_b && !sel_c_n) |-> (lane_we == '0));
    // R7: global write covers every lane
    a_r7_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_req && !wr_all_n && start_cpu_n && !start_ctl_n && !sel_a_n && sel_b && !sel_c_n)
        |-> (&lane_we));
    // R12: sleep blocks array access and new reads
    a_r12_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (lane_we == '0));
    a_r12_sleep_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !st_q.rd_v);
    // R11: flow-through drive held across the deselect edge
    a_r11_dcd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_DESEL && !st_q.dsel && !pipe_mode) |=> (pipe_mode || raw_v == $past(raw_v)));
endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
    localparam int AW = 6;
    localparam int LN = 4;
    localparam int DW = 32;
    localparam int DEPTH = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic          sel_a_n, sel_b, sel_c_n;
    logic          start_cpu_n, start_ctl_n, advance_n;
    logic          wr_all_n, wr_bytes_n;
    logic [LN-1:0] lane_n;
    logic          pipe_mode, linear_order, out_en_n, sleep_req;
    logic [DW-1:0] dout;
    logic          dout_drive;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [DW-1:0] m_mem [DEPTH];
    logic          m_active, m_rd_v, m_dsel, m_v2;
    logic [AW-1:0] m_base, m_rd_addr;
    logic [1:0]    m_cnt;
    logic [DW-1:0] m_dat;

    always #4 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .LANES(LN)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .advance_n(advance_n),
        .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n), .lane_n(lane_n),
        .pipe_mode(pipe_mode), .linear_order(linear_order),
        .out_en_n(out_en_n), .sleep_req(sleep_req),
        .dout(dout), .dout_drive(dout_drive)
    );

    function automatic logic [DW-1:0] wd(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {b, ~b, 8'hA5, b + 8'd3};
    endfunction

    task automatic chk(input string tag, input bit ok, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic sel, cpu;
        logic [LN-1:0] wm;
        logic [DW-1:0] nd;
        logic nv2, ld, st;
        logic [1:0] off;
        logic [AW-1:0] acc;
        int kind;
        if (!rst_n) begin
            m_active = 0; m_rd_v = 0; m_dsel = 0; m_v2 = 0;
            m_base = '0; m_rd_addr = '0; m_cnt = '0; m_dat = '0;
            return;
        end
        nd = m_mem[m_rd_addr];
        nv2 = m_rd_v;
        sel = !sel_a_n && sel_b && !sel_c_n;
        cpu = !start_cpu_n && sel;
        wm = !wr_all_n ? 4'hF : (!wr_bytes_n ? ~lane_n : 4'h0);
        ld = 0; st = 0; kind = 0;
        if (sleep_req) kind = 0;
        else if (cpu) begin ld = 1; kind = 2; m_active = 1; end
        else if (!start_ctl_n) begin
            if (sel) begin ld = 1; m_active = 1; kind = (wm != 0) ? 3 : 2; end
            else begin kind = 1; m_active = 0; end
        end else if (m_active) begin
            st = !advance_n; kind = (wm != 0) ? 3 : 2;
        end else kind = 1;
        if (ld) begin m_base = addr; m_cnt = 2'd0; end
        else if (st) m_cnt = m_cnt + 2'd1;
        off = linear_order ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
        acc = {m_base[AW-1:2], off};
        if (kind == 3) begin
            for (int i = 0; i < LN; i++)
                if (wm[i]) m_mem[acc][8*i +: 8] = din[8*i +: 8];
        end
        m_rd_addr = acc;
        m_rd_v = (kind == 2);
        m_dsel = (kind == 1);
        m_dat = nd;
        m_v2 = nv2;
    endtask

    task automatic compare(input string tag);
        logic ev, edrv;
        logic [DW-1:0] ed;
        if (pipe_mode || m_dsel) begin ev = m_v2; ed = m_dat; end
        else begin ev = m_rd_v; ed = m_mem[m_rd_addr]; end
        edrv = ev && !out_en_n && !sleep_req;
        chk(tag, dout_drive == edrv, {31'd0, dout_drive}, {31'd0, edrv});
        if (edrv) chk(tag, dout == ed, dout, ed);
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic chk_word(input string tag, input logic [DW-1:0] exp);
        chk(tag, dout_drive === 1'b1, {31'd0, dout_drive}, 32'd1);
        chk(tag, dout === exp, dout, exp);
    endtask

    task automatic chk_off(input string tag);
        chk(tag, dout_drive === 1'b0, {31'd0, dout_drive}, 32'd0);
    endtask

    task automatic idle();
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        start_cpu_n = 1; start_ctl_n = 1; advance_n = 1;
        wr_all_n = 1; wr_bytes_n = 1; lane_n = '1;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        rst_n = 0; addr = '0; din = '0;
        pipe_mode = 0; linear_order = 0; out_en_n = 0; sleep_req = 0;
        @(negedge clk);
        cyc("R14"); cyc("R14");
        chk_off("R14 in reset");
        rst_n = 1;
        cyc("R14"); chk_off("R14 after release");

        // fill through global writes with the byte controls held off (R7)
        for (int a = 0; a < DEPTH; a++) begin
            idle(); start_ctl_n = 0; wr_all_n = 0; wr_bytes_n = 1; lane_n = 4'hF;
            addr = AW'(a); din = wd(a);
            cyc("R7");
        end
        idle();

        // interleaved burst, flow-through (R5 R9)
        pipe_mode = 0; linear_order = 0;
        start_cpu_n = 0; addr = 6'd9; cyc("R9"); chk_word("R9 first flow data", wd(9));
        start_cpu_n = 1; advance_n = 0;
        cyc("R5"); chk_word("R5 step1", wd(8));
        cyc("R5"); chk_word("R5 step2", wd(11));
        cyc("R5"); chk_word("R5 step3", wd(10));
        cyc("R5"); chk_word("R5 wrap", wd(9));

        // linear burst, pipelined (R6 R10 R4)
        pipe_mode = 1; linear_order = 1; advance_n = 1;
        start_cpu_n = 0; addr = 6'd10; cyc("R10");
        start_cpu_n = 1; advance_n = 0;
        cyc("R10"); chk_word("R10 first piped data", wd(10));
        cyc("R6"); chk_word("R6 step1", wd(11));
        cyc("R6"); chk_word("R6 wrap", wd(8));
        advance_n = 1;
        cyc("R6"); chk_word("R6 step3", wd(9));
        cyc("R4"); chk_word("R4 hold repeats", wd(9));

        // byte write (R8 R3)
        idle(); pipe_mode = 0;
        start_ctl_n = 0; addr = 6'd20; wr_bytes_n = 0; lane_n = 4'b1010; din = 32'hDEADBEEF;
        cyc("R8"); chk_off("R3 write does not drive");
        idle(); start_ctl_n = 0; addr = 6'd20;
        cyc("R3"); chk_word("R8 lanes 0 and 2", {wd(20)[31:24], 8'hAD, wd(20)[15:8], 8'hEF});
        lane_n = 4'h0; wr_bytes_n = 1; din = '0;
        cyc("R8"); chk_word("R8 unqualified lanes read", {wd(20)[31:24], 8'hAD, wd(20)[15:8], 8'hEF});

        // processor start with global write asserted (R2)
        idle(); start_cpu_n = 0; wr_all_n = 0; addr = 6'd21; din = '0;
        cyc("R2"); chk_word("R2 cpu start reads", wd(21));

        // unselected processor strobe (R1)
        idle(); start_ctl_n = 0; addr = 6'd30;
        cyc("R1"); chk_word("R1 setup", wd(30));
        idle(); sel_a_n = 1; start_cpu_n = 0; addr = 6'd40;
        cyc("R1"); chk_word("R1 strobe ignored", wd(30));

        // deselect timing, flow then pipelined (R11)
        idle(); start_ctl_n = 0; addr = 6'd12;
        cyc("R11"); chk_word("R11 read", wd(12));
        sel_a_n = 1;
        cyc("R11"); chk_word("R11 flow held one edge", wd(12));
        idle();
        cyc("R11"); chk_off("R11 flow off at second edge");
        pipe_mode = 1;
        start_ctl_n = 0; addr = 6'd13; cyc("R11");
        sel_a_n = 1;
        cyc("R11"); chk_word("R11 piped data after deselect", wd(13));
        idle();
        cyc("R11"); chk_off("R11 piped off");

        // sleep (R12)
        pipe_mode = 0; idle(); start_ctl_n = 0; addr = 6'd16;
        cyc("R12"); chk_word("R12 setup", wd(16));
        sleep_req = 1; #1;
        chk_off("R12 async off");
        wr_all_n = 0; din = '0;
        cyc("R12"); cyc("R12");
        sleep_req = 0; idle(); start_ctl_n = 0; addr = 6'd16;
        cyc("R12"); chk_word("R12 contents kept", wd(16));

        // output enable (R13)
        idle(); start_ctl_n = 0; addr = 6'd17;
        cyc("R13"); chk_word("R13 setup", wd(17));
        idle(); advance_n = 1;
        out_en_n = 1; #1; chk_off("R13 async off");
        out_en_n = 0; #1; chk_word("R13 async on", wd(17));
        @(negedge clk);
        cyc("R13");

        // random traffic (R1..R13 via model)
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] r;
            r = $urandom;
            sel_a_n = (r[3:0] == 4'd0);
            sel_b = (r[7:4] != 4'd0);
            sel_c_n = (r[31:28] == 4'd0);
            start_cpu_n = r[8] | r[9];
            start_ctl_n = r[10] | r[11];
            advance_n = r[12];
            wr_all_n = r[13] | r[14] | r[15];
            wr_bytes_n = r[16];
            lane_n = r[20:17];
            linear_order = r[21];
            out_en_n = (r[25:22] == 4'd0);
            sleep_req = (r[27:26] == 2'd0) && r[9];
            if (n % 400 == 0) pipe_mode = ~pipe_mode;
            addr = AW'($urandom);
            din = $urandom;
            cyc("R4 R9 R10 R11 random");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule